// File: doc/BRIEF.md
# Legacy display address routing decoder

This block steers each processor-initiated cycle to one of two destinations: the graphics bridge or the downstream hub. A request carries a cycle kind (memory or I/O), a 32-bit address and a 4-bit byte-enable. A set of configuration inputs controls the routing: colour display enable, monochrome adapter present, ISA enable, and a 16-bit I/O base and limit for the graphics bridge. The block decodes the legacy colour and monochrome display ranges, applies the routing rules for the selected mode, and checks other I/O cycles against the bridge window.

When colour and monochrome support are both enabled, cycles are split between the two destinations. An I/O cycle goes to the hub as soon as any enabled byte lane lands on a monochrome register or on one of its aliases. The decision is registered behind a one-deep valid/ready stage. It comes out as a one-hot destination together with a flag that marks the illegal mode.

Top module: `legacy_route_dec`

## Requirements
- R1: `req_ready` is high whenever `rsp_valid` is low or `rsp_ready` is high. A request accepted at a clock edge (`req_valid && req_ready`) gives `rsp_valid` high after that same edge. While `rsp_valid && !rsp_ready`, the response holds unchanged and `req_ready` is low. Synchronous reset clears `rsp_valid`.
- R2: `rsp_dest` is one-hot whenever `rsp_valid` is high. Bit 0 selects the graphics bridge and bit 1 selects the hub.
- R3: The configuration inputs are sampled in the acceptance cycle. Changing them afterwards does not alter a pending response.
- R4: Colour enable low with monochrome present high is illegal. Such a request returns `rsp_cfg_err` = 1 and is routed as if both bits were low. In every other mode `rsp_cfg_err` = 0.
- R5: With colour enable low, every memory cycle goes to the hub. Every I/O cycle that touches a colour or monochrome I/O location also goes to the hub.
- R6: The memory ranges are colour A0000h–BFFFFh and monochrome B0000h–B7FFFh, compared on the full 32-bit address. With colour enabled, a colour-range cycle goes to the graphics bridge, except that monochrome-range cycles go to the hub when monochrome is present. Memory outside the colour range always goes to the hub.
- R7: Byte lane i (0..3) of an I/O cycle has the address {addr[15:2], i}. Only lanes whose `req_be` bit is set take part in the decode. Legacy I/O decode ignores address bits 15:10.
- R8: With colour enabled and monochrome absent, an I/O cycle that touches 3BFh (or an alias) goes to the hub. Otherwise, one that touches a colour I/O location (3B0h–3BBh or 3C0h–3DFh) goes to the graphics bridge.
- R9: With colour and monochrome both enabled, an I/O cycle that touches any monochrome location goes to the hub, even if other lanes are colour locations. The monochrome locations are 3B4h, 3B5h, 3B8h, 3B9h, 3BAh and 3BFh, and their aliases count too. Otherwise, a cycle that touches a colour location goes to the graphics bridge.
- R10: An I/O cycle that none of the legacy rules claim goes to the graphics bridge only if ISA enable is low and base ≤ A ≤ limit. A is the 16-bit address of the lowest enabled lane, or of lane 0 when no lane is enabled. Otherwise the cycle goes to the hub.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_is_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| req_addr | input | 32 | Cycle address |
| req_be | input | 4 | Byte-lane enables |
| cfg_vga_en | input | 1 | Colour display decode enable |
| cfg_mono_en | input | 1 | Monochrome adapter present |
| cfg_isa_en | input | 1 | ISA enable, blocks window forwarding |
| cfg_io_base | input | 16 | Graphics bridge I/O window low bound |
| cfg_io_limit | input | 16 | Graphics bridge I/O window high bound |
| rsp_valid | output | 1 | Decision available |
| rsp_ready | input | 1 | Decision consumed |
| rsp_dest | output | 2 | One-hot destination: bit 0 graphics, bit 1 hub |
| rsp_cfg_err | output | 1 | Request was decoded in the illegal mode |

## Verification
The block keeps only one state: the output register and its valid bit. Any wrong decode therefore shows at the ports one cycle after the request is accepted, as a wrong `rsp_dest` or `rsp_cfg_err`. A lost or stuck valid bit shows up as a missing response or as `req_ready` held low on the very next cycle. Lane masking and alias folding are covered by sweeping every byte-enable pattern at both an unaliased and an aliased base. The corner cases that matter are lanes straddling a colour and a monochrome location, and the window edges.

// File: rtl/legacy_route_pkg.sv
package legacy_route_pkg;

  typedef enum logic [1:0] {
    DEST_GFX = 2'b01,
    DEST_HUB = 2'b10
  } dest_e;

  // Per-request hit summary from the decoders
  typedef struct packed {
    logic io_mono;       // any lane on a monochrome register
    logic io_mono_only;  // any lane on the monochrome-only register
    logic io_vga;        // any lane on a colour register
    logic mem_mono;
    logic mem_vga;
    logic io_in_win;     // lowest lane inside bridge window, ISA clear
  } hit_t;

  typedef struct packed {
    logic vga_en;
    logic mono_en;
  } mode_t;

  localparam int LEG_DEC_BITS = 10;

  function automatic logic mono_io_loc(input logic [LEG_DEC_BITS-1:0] a);
    case (a)
      10'h3B4, 10'h3B5, 10'h3B8, 10'h3B9, 10'h3BA, 10'h3BF: mono_io_loc = 1'b1;
      default: mono_io_loc = 1'b0;
    endcase
  endfunction

  function automatic logic vga_io_loc(input logic [LEG_DEC_BITS-1:0] a);
    vga_io_loc = ((a >= 10'h3B0) && (a <= 10'h3BB)) ||
                 ((a >= 10'h3C0) && (a <= 10'h3DF));
  endfunction

endpackage

// File: rtl/lr_io_lane_match.sv
module lr_io_lane_match
  import legacy_route_pkg::*;
#(
  parameter int IO_W  = 16,
  parameter int LANES = 4
) (
  input  logic [IO_W-1:0]  io_addr,
  input  logic [LANES-1:0] lane_en,
  output logic             any_mono,
  output logic             any_mono_only,
  output logic             any_vga,
  output logic [IO_W-1:0]  low_lane_addr
);
  localparam int LANE_BITS = (LANES > 1) ? $clog2(LANES) : 1;

  logic [IO_W-1:0]  lane_addr [LANES];
  logic [LANES-1:0] hit_mono;
  logic [LANES-1:0] hit_mono_only;
  logic [LANES-1:0] hit_vga;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LEG_DEC_BITS-1:0] folded;
    assign lane_addr[i]     = {io_addr[IO_W-1:LANE_BITS], LANE_BITS'(i)};
    assign folded           = lane_addr[i][LEG_DEC_BITS-1:0];
    assign hit_mono[i]      = lane_en[i] & mono_io_loc(folded);
    assign hit_mono_only[i] = lane_en[i] & (folded == 10'h3BF);
    assign hit_vga[i]       = lane_en[i] & vga_io_loc(folded);
  end

  assign any_mono      = |hit_mono;
  assign any_mono_only = |hit_mono_only;
  assign any_vga       = |hit_vga;

  // Lowest enabled lane selects the window compare address
  always_comb begin
    low_lane_addr = lane_addr[0];
    for (int j = LANES - 1; j >= 0; j--) begin
      if (lane_en[j]) low_lane_addr = lane_addr[j];
    end
  end

endmodule

// File: rtl/lr_mem_match.sv
module lr_mem_match #(
  parameter int               AW      = 32,
  parameter logic [AW-1:0]    MONO_LO = AW'(32'h000B_0000),
  parameter logic [AW-1:0]    MONO_HI = AW'(32'h000B_7FFF),
  parameter logic [AW-1:0]    VGA_LO  = AW'(32'h000A_0000),
  parameter logic [AW-1:0]    VGA_HI  = AW'(32'h000B_FFFF)
) (
  input  logic [AW-1:0] addr,
  output logic          mono_hit,
  output logic          vga_hit
);
  assign mono_hit = (addr >= MONO_LO) && (addr <= MONO_HI);
  assign vga_hit  = (addr >= VGA_LO)  && (addr <= VGA_HI);
endmodule

// File: rtl/lr_io_window.sv
module lr_io_window #(
  parameter int IO_W = 16
) (
  input  logic [IO_W-1:0] addr,
  input  logic [IO_W-1:0] base,
  input  logic [IO_W-1:0] limit,
  input  logic            isa_en,
  output logic            fwd_ok
);
  assign fwd_ok = !isa_en && (addr >= base) && (addr <= limit);
endmodule

// File: rtl/lr_route_sel.sv
module lr_route_sel
  import legacy_route_pkg::*;
(
  input  logic  is_io,
  input  mode_t mode,
  input  hit_t  hit,
  output dest_e dest,
  output logic  cfg_err
);
  logic mono_eff;

  assign cfg_err  = !mode.vga_en && mode.mono_en;
  assign mono_eff = mode.vga_en && mode.mono_en;

  always_comb begin
    dest = DEST_HUB;
    if (!is_io) begin
      if (mode.vga_en && hit.mem_vga)
        dest = (mono_eff && hit.mem_mono) ? DEST_HUB : DEST_GFX;
    end else if (mode.vga_en) begin
      if (mono_eff ? hit.io_mono : hit.io_mono_only) dest = DEST_HUB;
      else if (hit.io_vga)                           dest = DEST_GFX;
      else if (hit.io_in_win)                        dest = DEST_GFX;
    end else begin
      if (hit.io_vga || hit.io_mono) dest = DEST_HUB;
      else if (hit.io_in_win)        dest = DEST_GFX;
    end
  end
endmodule

// File: rtl/legacy_route_dec.sv
module legacy_route_dec
  import legacy_route_pkg::*;
#(
  parameter int AW    = 32,
  parameter int IO_W  = 16,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_is_io,
  input  logic [AW-1:0]    req_addr,
  input  logic [LANES-1:0] req_be,
  input  logic             cfg_vga_en,
  input  logic             cfg_mono_en,
  input  logic             cfg_isa_en,
  input  logic [IO_W-1:0]  cfg_io_base,
  input  logic [IO_W-1:0]  cfg_io_limit,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [1:0]       rsp_dest,
  output logic             rsp_cfg_err
);
  hit_t      hit;
  mode_t     mode;
  dest_e     dest_nxt;
  logic      err_nxt;
  logic [IO_W-1:0] low_addr;
  logic      accept;

  assign mode = '{vga_en: cfg_vga_en, mono_en: cfg_mono_en};

  lr_io_lane_match #(.IO_W(IO_W), .LANES(LANES)) u_lanes (
    .io_addr       (req_addr[IO_W-1:0]),
    .lane_en       (req_be),
    .any_mono      (hit.io_mono),
    .any_mono_only (hit.io_mono_only),
    .any_vga       (hit.io_vga),
    .low_lane_addr (low_addr)
  );

  lr_mem_match #(.AW(AW)) u_mem (
    .addr     (req_addr),
    .mono_hit (hit.mem_mono),
    .vga_hit  (hit.mem_vga)
  );

  lr_io_window #(.IO_W(IO_W)) u_win (
    .addr   (low_addr),
    .base   (cfg_io_base),
    .limit  (cfg_io_limit),
    .isa_en (cfg_isa_en),
    .fwd_ok (hit.io_in_win)
  );

  lr_route_sel u_sel (
    .is_io   (req_is_io),
    .mode    (mode),
    .hit     (hit),
    .dest    (dest_nxt),
    .cfg_err (err_nxt)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_dest    <= DEST_HUB;
      rsp_cfg_err <= 1'b0;
    end else if (accept) begin
      rsp_valid   <= 1'b1;
      rsp_dest    <= dest_nxt;
      rsp_cfg_err <= err_nxt;
    end else if (rsp_ready) begin
      rsp_valid   <= 1'b0;
    end
  end

endmodule

// File: rtl/legacy_route_dec_chk.sv
module legacy_route_dec_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       req_ready,
  input logic       req_is_io,
  input logic       cfg_vga_en,
  input logic       cfg_mono_en,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [1:0] rsp_dest,
  input logic       rsp_cfg_err
);
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> !rsp_valid);

  a_r1_valid_after_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> rsp_valid);

  a_r1_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready && !(req_valid && req_ready)) |=>
      (rsp_valid && $stable(rsp_dest) && $stable(rsp_cfg_err)));

  a_r1_no_accept_on_stall: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  a_r2_onehot_dest: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($countones(rsp_dest) == 1));

  a_r4_err_flag: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (rsp_cfg_err == $past(!cfg_vga_en && cfg_mono_en)));

  a_r5_mem_hub_when_off: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_is_io && !cfg_vga_en) |=> (rsp_dest == 2'b10));
endmodule

bind legacy_route_dec legacy_route_dec_chk chk_i (.*);

// File: tb/legacy_route_dec_tb_top.sv
module legacy_route_dec_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_is_io = 1'b0;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_be = '0;
  logic        cfg_vga_en = 1'b0, cfg_mono_en = 1'b0, cfg_isa_en = 1'b0;
  logic [15:0] cfg_io_base = '0, cfg_io_limit = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [1:0]  rsp_dest;
  logic        rsp_cfg_err;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;

  legacy_route_dec dut_i (.*);

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
      summary();
    end
  end

  task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // Reference: returns {err, dest[1:0]}, dest 01 graphics, 10 hub
  function automatic logic [2:0] ref_route(input logic io, input logic [31:0] a,
      input logic [3:0] be, input logic vga, input logic mono, input logic isa,
      input logic [15:0] base, input logic [15:0] lim);
    logic err, mono_e, m_any, m_only, v_any, win;
    logic [15:0] low;
    logic [9:0] f;
    err    = !vga && mono;
    mono_e = vga && mono;
    if (!io) begin
      if (vga && a >= 32'hA0000 && a <= 32'hBFFFF) begin
        if (mono_e && a >= 32'hB0000 && a <= 32'hB7FFF) return {err, 2'b10};
        return {err, 2'b01};
      end
      return {err, 2'b10};
    end
    m_any = 0; m_only = 0; v_any = 0;
    low = {a[15:2], 2'd0};
    for (int k = 3; k >= 0; k--) begin
      if (be[k]) low = {a[15:2], 2'(k)};
    end
    for (int k = 0; k < 4; k++) begin
      if (be[k]) begin
        f = {a[9:2], 2'(k)};
        if (f inside {10'h3B4, 10'h3B5, 10'h3B8, 10'h3B9, 10'h3BA, 10'h3BF}) m_any = 1;
        if (f == 10'h3BF) m_only = 1;
        if ((f >= 10'h3B0 && f <= 10'h3BB) || (f >= 10'h3C0 && f <= 10'h3DF)) v_any = 1;
      end
    end
    win = !isa && low >= base && low <= lim;
    if (vga) begin
      if (mono_e ? m_any : m_only) return {err, 2'b10};
      if (v_any || win) return {err, 2'b01};
      return {err, 2'b10};
    end
    if (v_any || m_any) return {err, 2'b10};
    return {err, win ? 2'b01 : 2'b10};
  endfunction

  // One transaction: drive at negedge, accept at posedge, disturb config, check at negedge
  task automatic send(input string tag, input logic io, input logic [31:0] a,
                      input logic [3:0] be);
    logic [2:0] exp;
    exp = ref_route(io, a, be, cfg_vga_en, cfg_mono_en, cfg_isa_en, cfg_io_base, cfg_io_limit);
    req_is_io = io; req_addr = a; req_be = be; req_valid = 1'b1;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    // R3: config changes after acceptance must not reach the pending response
    cfg_vga_en = ~cfg_vga_en; cfg_mono_en = ~cfg_mono_en; cfg_isa_en = ~cfg_isa_en;
    @(negedge clk);
    chk({tag, " R1 valid"}, {2'b00, rsp_valid}, 3'b001);
    chk({tag, " R3 dest/err"}, {rsp_cfg_err, rsp_dest}, exp);
    cfg_vga_en = ~cfg_vga_en; cfg_mono_en = ~cfg_mono_en; cfg_isa_en = ~cfg_isa_en;
    @(negedge clk);
  endtask

  function automatic string io_tag(input logic v, input logic m, input logic [15:0] al);
    string t;
    if (!v && m) t = "R4";
    else if (!v) t = "R5";
    else if (!m) t = "R8";
    else t = "R9";
    if (al != 0) t = {t, " R7"};
    return t;
  endfunction

  logic [31:0] mem_pts [14] = '{32'h0009_FFFF, 32'h000A_0000, 32'h000A_8000, 32'h000A_FFFF,
                                32'h000B_0000, 32'h000B_4000, 32'h000B_7FFF, 32'h000B_8000,
                                32'h000B_FFFF, 32'h000C_0000, 32'h100B_0000, 32'h0000_03BF,
                                32'h000B_7FFE, 32'hFFFF_FFFF};

  logic [2:0]  e0, e1;
  logic [15:0] aliases [2] = '{16'h0000, 16'h8400};

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset rsp_valid", {2'b00, rsp_valid}, 3'b000);
    chk("R1 reset req_ready", {2'b00, req_ready}, 3'b001);
    rst = 1'b0;
    @(negedge clk);

    // Legacy I/O sweep: every mode, both alias bases, every byte-enable
    cfg_io_base = 16'h03A4; cfg_io_limit = 16'h03E1;
    for (int c = 0; c < 8; c++) begin
      for (int al = 0; al < 2; al++) begin
        for (int d = 16'h03A0; d <= 16'h03E4; d += 4) begin
          for (int be = 0; be < 16; be++) begin
            {cfg_vga_en, cfg_mono_en, cfg_isa_en} = 3'(c);
            send(io_tag(cfg_vga_en, cfg_mono_en, aliases[al]), 1'b1,
                 32'(d) | 32'(aliases[al]), 4'(be));
          end
        end
      end
    end

    // Bridge window edges with non-legacy I/O
    cfg_io_base = 16'h1040; cfg_io_limit = 16'h10BF;
    for (int c = 0; c < 8; c++) begin
      for (int d = 16'h1038; d <= 16'h10C4; d += 4) begin
        for (int be = 0; be < 16; be++) begin
          {cfg_vga_en, cfg_mono_en, cfg_isa_en} = 3'(c);
          send("R10", 1'b1, 32'(d), 4'(be));
        end
      end
    end

    // Memory range boundaries in every mode
    for (int c = 0; c < 8; c++) begin
      for (int p = 0; p < 14; p++) begin
        {cfg_vga_en, cfg_mono_en, cfg_isa_en} = 3'(c);
        send((c[2:1] == 2'b01) ? "R4 R6" : "R6", 1'b0, mem_pts[p], 4'hF);
      end
    end

    // R1 backpressure: hold response, block new request, then hand over
    cfg_vga_en = 1; cfg_mono_en = 1; cfg_isa_en = 0;
    e0 = ref_route(1'b0, 32'h000A_1000, 4'hF, 1, 1, 0, cfg_io_base, cfg_io_limit);
    e1 = ref_route(1'b0, 32'h000B_1000, 4'hF, 1, 1, 0, cfg_io_base, cfg_io_limit);
    rsp_ready = 1'b0;
    req_is_io = 0; req_addr = 32'h000A_1000; req_valid = 1;
    @(posedge clk); #1;
    req_addr = 32'h000B_1000;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R1 stall ready low", {2'b00, req_ready}, 3'b000);
      chk("R1 stall hold", {rsp_cfg_err, rsp_dest}, e0);
    end
    rsp_ready = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
    chk("R1 handover valid", {2'b00, rsp_valid}, 3'b001);
    chk("R1 handover dest", {rsp_cfg_err, rsp_dest}, e1);
    @(negedge clk);
    chk("R1 drained", {2'b00, rsp_valid}, 3'b000);

    // R2: one-hot encoding of a known graphics and hub result
    send("R2 gfx", 1'b0, 32'h000A_0000, 4'hF);
    chk("R2 gfx code", {1'b0, rsp_dest}, 3'b001);
    send("R2 hub", 1'b0, 32'h000B_0000, 4'hF);
    chk("R2 hub code", {1'b0, rsp_dest}, 3'b010);

    summary();
  end
endmodule